// File: doc/BRIEF.md
# Indexed CRT Controller Register Bank with Write Lock

This block holds the configuration bytes of a CRT display controller behind a two-port indirect access scheme. Software first writes a register number to the index port and then reads or writes the selected byte through the data port. Both ports appear at two alias addresses each, so software written for either the monochrome or the colour address layout reaches the same storage.

A protection rule guards the low timing registers. When the lock flag (bit 7 of register 0x11) is set, data writes aimed at registers 0 through 7 are discarded, except that bit 4 of register 7 still follows the written value. Register 0x11 itself is never guarded, so the lock can always be released. The read path is combinational from the bus address, so a read completes in the same cycle it is presented.

Top module: `crtc_regbank`

## Requirements
- R1: The bank holds 256 registers of 8 bits and an 8-bit index; after reset the index and every register are zero.
- R2: A write to bus address 0x4 or 0xC (the two index aliases) loads bus_wdata into the index on that clock edge.
- R3: With bus_addr at 0x4 or 0xC, bus_rdata shows the current index in the same cycle.
- R4: With bus_addr at 0x5 or 0xD (the two data aliases), bus_rdata shows the register selected by the index in the same cycle.
- R5: The lock flag is bit 7 of register 0x11; while it is 1, a data write with index 0 to 6 leaves the selected register unchanged, and other bits of register 0x11 have no effect on the lock.
- R6: While locked, a data write with index 7 copies bit 4 of bus_wdata into bit 4 of register 7 and keeps its other seven bits.
- R7: With the lock clear, or with an index above 7, a data write stores the whole byte; register 0x11 is always writable, so the lock can be cleared.
- R8: Reads of any address other than 0x4, 0x5, 0xC, 0xD return zero, and writes to them change neither the index nor any register.
- R9: A read and a write of the data port in the same cycle return the value held before the write; the new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears index and registers |
| bus_addr | input | 4 | Bus address selecting index port, data port or nothing |
| bus_we | input | 1 | Write strobe, acts on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address, index and storage |

## Verification
The data-port read and the data-port write can fall in the same cycle, because the read path is combinational while the write lands on the clock edge. The bench provokes this by holding a data alias address with the write strobe raised and sampling bus_rdata before the edge, expecting the old byte, then sampling again after the edge and expecting the new byte (or the masked result when the lock applies). The lock change and a guarded write are also placed back to back, so the write directly following the lock-setting write is judged against the locked rule.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

  // Which port a bus address reaches
  typedef enum logic [1:0] {
    PORT_NONE  = 2'd0,
    PORT_INDEX = 2'd1,
    PORT_DATA  = 2'd2
  } port_e;

endpackage

// File: rtl/crtc_addr_decode.sv
module crtc_addr_decode
  import crtc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int IDX_ADDR_A = 4,
  parameter int DAT_ADDR_A = 5,
  parameter int IDX_ADDR_B = 12,
  parameter int DAT_ADDR_B = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output port_e             kind
);

  function automatic port_e classify(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(IDX_ADDR_A) || a == ADDR_W'(IDX_ADDR_B))
      return PORT_INDEX;
    else if (a == ADDR_W'(DAT_ADDR_A) || a == ADDR_W'(DAT_ADDR_B))
      return PORT_DATA;
    else
      return PORT_NONE;
  endfunction

  assign kind = classify(addr);

endmodule

// File: rtl/crtc_lock_guard.sv
module crtc_lock_guard #(
  parameter int DATA_W     = 8,
  parameter int INDEX_W    = 8,
  parameter int PROT_LAST  = 7,
  parameter int EXEMPT_IDX = 7,
  parameter int EXEMPT_BIT = 4
) (
  input  logic               lock_bit,
  input  logic [INDEX_W-1:0] idx,
  output logic               prot_hit,
  output logic [DATA_W-1:0]  wr_mask
);

  // Bits of the selected register that a data write may change
  function automatic logic [DATA_W-1:0] allowed_bits(
    input logic               locked,
    input logic [INDEX_W-1:0] sel
  );
    logic [DATA_W-1:0] m;
    if (locked && (sel <= INDEX_W'(PROT_LAST))) begin
      m = '0;
      if (sel == INDEX_W'(EXEMPT_IDX))
        m[EXEMPT_BIT] = 1'b1;
    end else begin
      m = '1;
    end
    return m;
  endfunction

  assign prot_hit = lock_bit && (idx <= INDEX_W'(PROT_LAST));
  assign wr_mask  = allowed_bits(lock_bit, idx);

endmodule

// File: rtl/crtc_reg_store.sv
module crtc_reg_store #(
  parameter int DATA_W   = 8,
  parameter int INDEX_W  = 8,
  parameter int LOCK_IDX = 17,
  parameter int LOCK_BIT = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [INDEX_W-1:0] idx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  mask,
  output logic [DATA_W-1:0]  sel_val,
  output logic               lock_bit
);

  localparam int NREG = 1 << INDEX_W;

  function automatic logic [DATA_W-1:0] merge(
    input logic [DATA_W-1:0] old_v,
    input logic [DATA_W-1:0] new_v,
    input logic [DATA_W-1:0] m
  );
    return (old_v & ~m) | (new_v & m);
  endfunction

  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic hit;
    assign hit = we && (idx == INDEX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= '0;
      else if (hit)
        regs_q[g] <= merge(regs_q[g], wdata, mask);
    end
  end

  assign sel_val  = regs_q[idx];
  assign lock_bit = regs_q[LOCK_IDX][LOCK_BIT];

endmodule

// File: rtl/crtc_regbank.sv
module crtc_regbank
  import crtc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int INDEX_W    = 8,
  parameter int IDX_ADDR_A = 4,
  parameter int DAT_ADDR_A = 5,
  parameter int IDX_ADDR_B = 12,
  parameter int DAT_ADDR_B = 13,
  parameter int LOCK_IDX   = 17,
  parameter int LOCK_BIT   = 7,
  parameter int PROT_LAST  = 7,
  parameter int EXEMPT_IDX = 7,
  parameter int EXEMPT_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  // Named internal events, observed by the bound checker
  port_e              kind;
  logic               idx_we;
  logic               data_we;
  logic               lock_on;
  logic               prot_hit;
  logic [DATA_W-1:0]  wr_mask;
  logic [DATA_W-1:0]  sel_q;
  logic [INDEX_W-1:0] idx_q;

  crtc_addr_decode #(
    .ADDR_W    (ADDR_W),
    .IDX_ADDR_A(IDX_ADDR_A),
    .DAT_ADDR_A(DAT_ADDR_A),
    .IDX_ADDR_B(IDX_ADDR_B),
    .DAT_ADDR_B(DAT_ADDR_B)
  ) u_dec (
    .addr(bus_addr),
    .kind(kind)
  );

  assign idx_we  = bus_we && (kind == PORT_INDEX);
  assign data_we = bus_we && (kind == PORT_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_we)
      idx_q <= bus_wdata[INDEX_W-1:0];
  end

  crtc_lock_guard #(
    .DATA_W    (DATA_W),
    .INDEX_W   (INDEX_W),
    .PROT_LAST (PROT_LAST),
    .EXEMPT_IDX(EXEMPT_IDX),
    .EXEMPT_BIT(EXEMPT_BIT)
  ) u_guard (
    .lock_bit(lock_on),
    .idx     (idx_q),
    .prot_hit(prot_hit),
    .wr_mask (wr_mask)
  );

  crtc_reg_store #(
    .DATA_W  (DATA_W),
    .INDEX_W (INDEX_W),
    .LOCK_IDX(LOCK_IDX),
    .LOCK_BIT(LOCK_BIT)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (data_we),
    .idx     (idx_q),
    .wdata   (bus_wdata),
    .mask    (wr_mask),
    .sel_val (sel_q),
    .lock_bit(lock_on)
  );

  always_comb begin
    unique case (kind)
      PORT_INDEX: bus_rdata = DATA_W'(idx_q);
      PORT_DATA:  bus_rdata = sel_q;
      default:    bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/crtc_regbank_chk.sv
module crtc_regbank_chk
  import crtc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int INDEX_W    = 8,
  parameter int PROT_LAST  = 7,
  parameter int EXEMPT_IDX = 7,
  parameter int EXEMPT_BIT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_we,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input port_e              kind,
  input logic               data_we,
  input logic               lock_on,
  input logic               prot_hit,
  input logic [DATA_W-1:0]  sel_q,
  input logic [INDEX_W-1:0] idx_q
);

  localparam logic [DATA_W-1:0] EX_M = DATA_W'(1) << EXEMPT_BIT;

  AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && kind == PORT_INDEX) |=> idx_q == $past(bus_wdata[INDEX_W-1:0])); // R2

  AST_IDX_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PORT_INDEX) |-> bus_rdata == DATA_W'(idx_q)); // R3

  AST_DATA_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PORT_DATA) |-> bus_rdata == sel_q); // R4

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && lock_on && idx_q <= INDEX_W'(PROT_LAST) && idx_q != INDEX_W'(EXEMPT_IDX))
    |=> sel_q == $past(sel_q)); // R5

  AST_EXEMPT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && lock_on && idx_q == INDEX_W'(EXEMPT_IDX))
    |=> sel_q == (($past(sel_q) & ~EX_M) | ($past(bus_wdata) & EX_M))); // R6

  AST_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !prot_hit) |=> sel_q == $past(bus_wdata)); // R7

  AST_UNDEC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == PORT_NONE) |-> bus_rdata == '0); // R8

  AST_UNDEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && kind == PORT_NONE) |=> (idx_q == $past(idx_q) && sel_q == $past(sel_q))); // R8

endmodule

bind crtc_regbank crtc_regbank_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_we   (bus_we),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .kind     (kind),
  .data_we  (data_we),
  .lock_on  (lock_on),
  .prot_hit (prot_hit),
  .sel_q    (sel_q),
  .idx_q    (idx_q)
);

// File: tb/crtc_regbank_test.sv
`timescale 1ns/1ps
module crtc_regbank_test;

  localparam logic [3:0] IDX_A = 4'h4;
  localparam logic [3:0] DAT_A = 4'h5;
  localparam logic [3:0] IDX_B = 4'hC;
  localparam logic [3:0] DAT_B = 4'hD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  crtc_regbank uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_we   = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_reg(input logic [7:0] i, input logic [7:0] v);
    wr(IDX_A, i);
    wr(DAT_A, v);
  endtask

  task automatic expect_reg(input string req, input logic [7:0] i, input logic [7:0] v);
    logic [7:0] r;
    wr(IDX_B, i);
    rd(DAT_B, r);
    check(req, r, v);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    rd(IDX_A, r); check("R1 index after reset", r, 8'h00);
    rd(DAT_A, r); check("R1 reg0 after reset", r, 8'h00);
    expect_reg("R1 reg 0x11 after reset", 8'h11, 8'h00);
    expect_reg("R1 reg 0xFF after reset", 8'hFF, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] r;
    wr(IDX_A, 8'h23); rd(IDX_B, r); check("R2 R3 index via alias A read at B", r, 8'h23);
    wr(IDX_B, 8'hC5); rd(IDX_A, r); check("R2 R3 index via alias B read at A", r, 8'hC5);
  endtask

  task automatic t_data();
    logic [7:0] r;
    wr(IDX_A, 8'h30); wr(DAT_A, 8'hA5);
    rd(DAT_B, r); check("R4 data alias B reads reg 0x30", r, 8'hA5);
    wr(IDX_A, 8'hFF); wr(DAT_B, 8'h3C);
    rd(DAT_A, r); check("R4 data alias A reads reg 0xFF", r, 8'h3C);
    expect_reg("R4 reg 0x30 kept", 8'h30, 8'hA5);
  endtask

  task automatic t_lock();
    // unlocked setup
    set_reg(8'h03, 8'h11);
    set_reg(8'h07, 8'h2A);
    set_reg(8'h02, 8'h44);
    // bits other than 7 of reg 0x11 do not lock
    set_reg(8'h11, 8'h7F);
    set_reg(8'h02, 8'h99);
    expect_reg("R5 low bits of 0x11 do not lock", 8'h02, 8'h99);
    // lock, then guarded write right after
    set_reg(8'h11, 8'h80);
    wr(IDX_A, 8'h03); wr(DAT_A, 8'hEE);
    expect_reg("R5 locked reg3 unchanged", 8'h03, 8'h11);
    set_reg(8'h00, 8'hFF);
    expect_reg("R5 locked reg0 unchanged", 8'h00, 8'h00);
    set_reg(8'h07, 8'hFF);
    expect_reg("R6 locked reg7 bit4 set only", 8'h07, 8'h3A);
    set_reg(8'h07, 8'h00);
    expect_reg("R6 locked reg7 bit4 cleared only", 8'h07, 8'h2A);
    set_reg(8'h08, 8'h5C);
    expect_reg("R7 reg8 writable while locked", 8'h08, 8'h5C);
    set_reg(8'h11, 8'h00);
    expect_reg("R7 lock register writable", 8'h11, 8'h00);
    set_reg(8'h03, 8'hEE);
    expect_reg("R7 reg3 writable after unlock", 8'h03, 8'hEE);
    set_reg(8'h07, 8'hC3);
    expect_reg("R7 reg7 full byte after unlock", 8'h07, 8'hC3);
  endtask

  task automatic t_undecoded();
    logic [7:0] r;
    set_reg(8'h50, 8'h66);
    for (int a = 0; a < 16; a++) begin
      if (a != 4 && a != 5 && a != 12 && a != 13) begin
        wr(4'(a), 8'h77);
        rd(4'(a), r);
        check($sformatf("R8 undecoded read addr %0d", a), r, 8'h00);
      end
    end
    rd(IDX_A, r); check("R8 index untouched by undecoded writes", r, 8'h50);
    rd(DAT_A, r); check("R8 reg untouched by undecoded writes", r, 8'h66);
  endtask

  task automatic t_collide();
    logic [7:0] r;
    set_reg(8'h40, 8'h12);
    @(negedge clk);
    bus_addr  = DAT_A;
    bus_we    = 1'b1;
    bus_wdata = 8'h34;
    #1;
    check("R9 same-cycle read shows old value", bus_rdata, 8'h12);
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    check("R9 next cycle shows new value", bus_rdata, 8'h34);
    // collision under lock on a guarded register
    set_reg(8'h05, 8'h21);
    set_reg(8'h11, 8'h80);
    wr(IDX_A, 8'h05);
    @(negedge clk);
    bus_addr  = DAT_B;
    bus_we    = 1'b1;
    bus_wdata = 8'hFF;
    #1;
    check("R9 R5 same-cycle read under lock", bus_rdata, 8'h21);
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    check("R5 guarded reg after collision", bus_rdata, 8'h21);
    set_reg(8'h11, 8'h00);
    rd(DAT_A, r);
    check("R7 lock cleared reads back", r, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_data();
    t_lock();
    t_undecoded();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule